// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 64 words, each 18 bits wide. Words enter on the load clock and leave on the unload clock. The two clocks may be unrelated or may be the same clock. Each pointer crosses into the other domain as a Gray code through a two-flop synchronizer. The full flag is decided in the load domain and the empty flag in the unload domain.

Reads fall through. The oldest stored word is always present on `dataOut`, so an unload strobe takes away the word already on view. Four flags report the fill level: an active-low full flag, an active-low empty flag, a half-full flag, and one threshold flag. The threshold flag is high near either end of the buffer.

The two thresholds for that flag are loaded in-band. With `progEnN` low, the first load strobes after reset take the offsets from the low bits of `dataIn` instead of storing a word. An output-enable input gates a separate valid signal that stands in for a three-state output.

Top module: `twoclk_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with no loss and no duplication.
- R2: A word is accepted on a rising `ldClk` edge with `ldEn` high, and removed on a rising `unClk` edge with `unEn` high. The block works both with one shared clock and with two unrelated clocks.
- R3: A load strobe while full leaves the stored words unchanged. An unload strobe while empty leaves the read position unchanged.
- R4: `fullN` is low exactly when the load-domain count equals 64. This count is loads accepted minus unloads seen through the synchronizer.
- R5: `emptyN` is low exactly when the unload domain sees no stored word. It rises by the second `unClk` edge after a load into an empty buffer. It falls right after the unload edge that removes the last word.
- R6: `halfFull` is high when the load-domain count is 32 or more, and low when it is 31 or less.
- R7: `almostFlag` is high when the count is at most X or at least 64-Y, and low otherwise.
- R8: With `progEnN` low, the first load strobe after reset sets X from `dataIn[5:0]`. A second strobe with `progEnN` still low sets Y from `dataIn[5:0]`. Neither word is stored.
- R9: If `progEnN` is high on the second strobe, Y takes X's value and that word is stored. If `progEnN` is high on the first strobe, X and Y stay at 8 and that word is stored.
- R10: An active-low `rstN` empties the buffer. It sets `fullN` high, `emptyN` low, `halfFull` low and `almostFlag` high, and restarts offset programming.
- R11: The oldest stored word appears on `dataOut` without an unload strobe.
- R12: `dataValid` is the inverse of `oeN`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ldClk | input | 1 | Load-side clock |
| unClk | input | 1 | Unload-side clock |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| ldEn | input | 1 | Load strobe |
| progEnN | input | 1 | Active-low enable for offset programming |
| dataIn | input | 18 | Write data and offset programming value |
| unEn | input | 1 | Unload strobe |
| oeN | input | 1 | Active-low output enable |
| dataOut | output | 18 | Oldest stored word (fall-through) |
| dataValid | output | 1 | High when the output is enabled |
| fullN | output | 1 | Low when full |
| emptyN | output | 1 | Low when empty |
| halfFull | output | 1 | High at 32 or more words |
| almostFlag | output | 1 | High near empty (count at most X) or near full (count at least 64-Y) |

## Verification
A shared clock makes the flag timing exact, so the buffer is filled word by word from 0 to 64 and drained back to 0. The flags are compared at every count under three offset setups: both offsets programmed, defaults kept, and Y copied from X. This separates a wrong threshold, a swapped offset, and a programming word stored by mistake. Loading into a full buffer and unloading from an empty one are each followed by traffic that would expose a moved pointer. A last run uses two unrelated clocks and a scoreboard over several hundred strobes, including long stretches at full. This exposes ordering or crossing faults that the lock-step sweeps cannot.

// File: rtl/twoclk_fifo_pkg.sv
package twoclk_fifo_pkg;

  // Progress of in-band offset programming after reset.
  typedef enum logic [1:0] {
    PROG_LOW  = 2'd0,
    PROG_HIGH = 2'd1,
    PROG_DONE = 2'd2
  } progPhase_t;

  // Strobes sent from control to datapath.
  typedef struct packed {
    logic wrEn;      // store dataIn at wrAddr
    logic capLow;    // capture near-empty offset from dataIn
    logic capHigh;   // capture near-full offset from dataIn
    logic copyHigh;  // near-full offset takes the near-empty value
  } dpStrobe_t;

endpackage

// File: rtl/twoclk_fifo_sync.sv
module twoclk_fifo_sync #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

endmodule

// File: rtl/twoclk_fifo_ctrl.sv
module twoclk_fifo_ctrl
  import twoclk_fifo_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              ldClk,
  input  logic              unClk,
  input  logic              rstN,
  input  logic              ldEn,
  input  logic              progEnN,
  input  logic              unEn,
  input  logic [ADDR_W-1:0] lowOfs,
  input  logic [ADDR_W-1:0] highOfs,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullN,
  output logic              emptyN,
  output logic              halfFull,
  output logic              almostFlag
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_P  = PTR_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] ONE_P   = PTR_W'(1);

  // ---------------- load domain ----------------
  logic [PTR_W-1:0] wrBin, wrBinNext, wrGray;
  logic [PTR_W-1:0] rdGraySync, rdBinSync, wrCount;
  progPhase_t       phase, phaseNext;
  logic             progWord, isFull, loadFire;

  always_comb begin
    phaseNext       = phase;
    progWord        = 1'b0;
    strobe.capLow   = 1'b0;
    strobe.capHigh  = 1'b0;
    strobe.copyHigh = 1'b0;
    if (ldEn) begin
      case (phase)
        PROG_LOW: begin
          phaseNext     = progEnN ? PROG_DONE : PROG_HIGH;
          progWord      = !progEnN;
          strobe.capLow = !progEnN;
        end
        PROG_HIGH: begin
          phaseNext       = PROG_DONE;
          progWord        = !progEnN;
          strobe.capHigh  = !progEnN;
          strobe.copyHigh = progEnN;
        end
        default: ;
      endcase
    end
  end

  assign wrBinNext   = wrBin + ONE_P;
  assign wrCount     = wrBin - rdBinSync;
  assign isFull      = (wrCount == DEPTH_P);
  assign loadFire    = ldEn && !progWord && !isFull;
  assign strobe.wrEn = loadFire;

  always_ff @(posedge ldClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
      phase  <= PROG_LOW;
    end else begin
      phase <= phaseNext;
      if (loadFire) begin
        wrBin  <= wrBinNext;
        wrGray <= wrBinNext ^ (wrBinNext >> 1);
      end
    end
  end

  twoclk_fifo_sync #(.WIDTH(PTR_W)) rdToLd (
    .clk (ldClk),
    .rstN(rstN),
    .din (rdGray),
    .dout(rdGraySync)
  );

  // Gray to binary: each bit is the parity of the code from that bit up.
  for (genvar i = 0; i < PTR_W; i++) begin : g_rdDecode
    assign rdBinSync[i] = ^(rdGraySync >> i);
  end

  assign fullN      = !isFull;
  assign halfFull   = (wrCount >= HALF_P);
  assign almostFlag = (wrCount <= {1'b0, lowOfs}) ||
                      (wrCount >= (DEPTH_P - {1'b0, highOfs}));
  assign wrAddr     = wrBin[ADDR_W-1:0];

  // ---------------- unload domain ----------------
  logic [PTR_W-1:0] rdBin, rdBinNext, rdGray;
  logic [PTR_W-1:0] wrGraySync, wrBinSync, rdCount;
  logic             isEmpty, unloadFire;

  twoclk_fifo_sync #(.WIDTH(PTR_W)) wrToUn (
    .clk (unClk),
    .rstN(rstN),
    .din (wrGray),
    .dout(wrGraySync)
  );

  for (genvar i = 0; i < PTR_W; i++) begin : g_wrDecode
    assign wrBinSync[i] = ^(wrGraySync >> i);
  end

  assign rdBinNext  = rdBin + ONE_P;
  assign isEmpty    = (rdGray == wrGraySync);
  assign unloadFire = unEn && !isEmpty;
  assign rdCount    = wrBinSync - rdBin;

  always_ff @(posedge unClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (unloadFire) begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
    end
  end

  assign emptyN = !isEmpty;
  assign rdAddr = rdBin[ADDR_W-1:0];

  // ---------------- assertions ----------------
  a_r3_no_overflow: assert property (@(posedge ldClk) disable iff (!rstN)
    (ldEn && !fullN) |=> $stable(wrBin));

  a_r3_no_underflow: assert property (@(posedge unClk) disable iff (!rstN)
    (unEn && !emptyN) |=> $stable(rdBin));

  a_r4_count_bound: assert property (@(posedge ldClk) disable iff (!rstN)
    wrCount <= DEPTH_P);

  a_r5_read_behind_write: assert property (@(posedge unClk) disable iff (!rstN)
    rdCount <= DEPTH_P);

  a_r6_full_implies_half: assert property (@(posedge ldClk) disable iff (!rstN)
    !fullN |-> halfFull);

  a_r8_program_once: assert property (@(posedge ldClk) disable iff (!rstN)
    (phase == PROG_DONE) |=> (phase == PROG_DONE));

  a_r2_wr_gray_step: assert property (@(posedge ldClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  a_r2_rd_gray_step: assert property (@(posedge unClk) disable iff (!rstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);

endmodule

// File: rtl/twoclk_fifo_data.sv
module twoclk_fifo_data
  import twoclk_fifo_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int ADDR_W  = 6,
  parameter int DEF_OFS = 8
) (
  input  logic              ldClk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [ADDR_W-1:0] lowOfs,
  output logic [ADDR_W-1:0] highOfs
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] DEF_P = ADDR_W'(DEF_OFS);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge ldClk) begin
    if (strobe.wrEn) store[wrAddr] <= dataIn;
  end

  always_ff @(posedge ldClk or negedge rstN) begin
    if (!rstN) begin
      lowOfs  <= DEF_P;
      highOfs <= DEF_P;
    end else begin
      if (strobe.capLow)   lowOfs  <= dataIn[ADDR_W-1:0];
      if (strobe.capHigh)  highOfs <= dataIn[ADDR_W-1:0];
      if (strobe.copyHigh) highOfs <= lowOfs;
    end
  end

  // Fall-through read: head word is always driven.
  assign dataOut = store[rdAddr];

  a_r8_prog_not_stored: assert property (@(posedge ldClk) disable iff (!rstN)
    (strobe.capLow || strobe.capHigh) |-> !strobe.wrEn);

  a_r8_one_offset_op: assert property (@(posedge ldClk) disable iff (!rstN)
    $onehot0({strobe.capLow, strobe.capHigh, strobe.copyHigh}));

  a_r9_copy_offset: assert property (@(posedge ldClk) disable iff (!rstN)
    strobe.copyHigh |=> (highOfs == $past(lowOfs)));

endmodule

// File: rtl/twoclk_fifo.sv
module twoclk_fifo
  import twoclk_fifo_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int ADDR_W  = 6,
  parameter int DEF_OFS = 8
) (
  input  logic              ldClk,
  input  logic              unClk,
  input  logic              rstN,
  input  logic              ldEn,
  input  logic              progEnN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              unEn,
  input  logic              oeN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              fullN,
  output logic              emptyN,
  output logic              halfFull,
  output logic              almostFlag
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr, lowOfs, highOfs;

  twoclk_fifo_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .ldClk     (ldClk),
    .unClk     (unClk),
    .rstN      (rstN),
    .ldEn      (ldEn),
    .progEnN   (progEnN),
    .unEn      (unEn),
    .lowOfs    (lowOfs),
    .highOfs   (highOfs),
    .strobe    (strobe),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr),
    .fullN     (fullN),
    .emptyN    (emptyN),
    .halfFull  (halfFull),
    .almostFlag(almostFlag)
  );

  twoclk_fifo_data #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DEF_OFS(DEF_OFS)
  ) data (
    .ldClk  (ldClk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .dataIn (dataIn),
    .dataOut(dataOut),
    .lowOfs (lowOfs),
    .highOfs(highOfs)
  );

  assign dataValid = !oeN;

endmodule

// File: tb/twoclk_fifo_test.sv
module twoclk_fifo_test;

  logic        ldClk = 1'b0;
  logic        unClkFree = 1'b0;
  logic        asyncMode = 1'b0;
  logic        unClk;
  logic        rstN = 1'b0;
  logic        ldEn = 1'b0;
  logic        progEnN = 1'b1;
  logic [17:0] dataIn = '0;
  logic        unEn = 1'b0;
  logic        oeN = 1'b0;
  logic [17:0] dataOut;
  logic        dataValid, fullN, emptyN, halfFull, almostFlag;

  int checks = 0;
  int fails  = 0;

  always #5 ldClk = ~ldClk;       // 100 MHz
  always #7 unClkFree = ~unClkFree;
  assign unClk = asyncMode ? unClkFree : ldClk;

  twoclk_fifo uut (
    .ldClk(ldClk), .unClk(unClk), .rstN(rstN), .ldEn(ldEn),
    .progEnN(progEnN), .dataIn(dataIn), .unEn(unEn), .oeN(oeN),
    .dataOut(dataOut), .dataValid(dataValid), .fullN(fullN),
    .emptyN(emptyN), .halfFull(halfFull), .almostFlag(almostFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int afExp(int n, int x, int y);
    return ((n <= x) || (n >= 64 - y)) ? 1 : 0;
  endfunction

  task automatic doReset();
    rstN = 1'b0; ldEn = 1'b0; unEn = 1'b0; progEnN = 1'b1; dataIn = '0;
    repeat (3) @(negedge ldClk);
    rstN = 1'b1;
    @(negedge ldClk);
  endtask

  task automatic loadOne(input logic [17:0] d, input logic pen);
    ldEn = 1'b1; dataIn = d; progEnN = pen;
    @(negedge ldClk);
    ldEn = 1'b0; progEnN = 1'b1;
  endtask

  task automatic flagCheck(input int n, input int x, input int y);
    chk("R4 fullN", int'(fullN), (n < 64) ? 1 : 0);
    chk("R6 halfFull", int'(halfFull), (n >= 32) ? 1 : 0);
    chk("R7 almostFlag", int'(almostFlag), afExp(n, x, y));
  endtask

  // Fill with words base..base+63 (progEnN high); first word may be the
  // second strobe after reset when X was programmed.
  task automatic fillSweep(input int base, input int x, input int y);
    for (int n = 1; n <= 64; n++) begin
      loadOne(18'(base + n - 1), 1'b1);
      flagCheck(n, x, y);
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [17:0] q[$];
    bit prodDone;
    // ---------- Test A: programmed offsets X=3, Y=5 ----------
    doReset();
    chk("R10 fullN", int'(fullN), 1);
    chk("R10 emptyN", int'(emptyN), 0);
    chk("R10 halfFull", int'(halfFull), 0);
    chk("R10 almostFlag", int'(almostFlag), 1);
    oeN = 1'b1; #1;
    chk("R12 valid off", int'(dataValid), 0);
    oeN = 1'b0; #1;
    chk("R12 valid on", int'(dataValid), 1);

    loadOne(18'd3, 1'b0);            // X
    loadOne(18'd5, 1'b0);            // Y
    chk("R8 prog words not stored", int'(emptyN), 0);
    loadOne(18'd1000, 1'b1);         // first data word
    chk("R5 empty still low after edge", int'(emptyN), 0);
    flagCheck(1, 3, 5);
    repeat (2) @(negedge ldClk);
    chk("R5 emptyN high after sync", int'(emptyN), 1);
    chk("R11 fall-through head", int'(dataOut), 1000);
    for (int n = 2; n <= 64; n++) begin
      loadOne(18'(1000 + (n - 1) * 3), 1'b1);
      flagCheck(n, 3, 5);
    end
    loadOne(18'h3FFFF, 1'b1);        // load while full
    chk("R3 full stays", int'(fullN), 0);
    chk("R3 head unchanged when full", int'(dataOut), 1000);

    for (int i = 0; i < 64; i++) begin
      chk("R1 order", int'(dataOut), 1000 + i * 3);
      unEn = 1'b1;
      @(negedge ldClk);
      unEn = 1'b0;
      if (i == 63) chk("R5 emptyN falls", int'(emptyN), 0);
      else         chk("R5 emptyN held", int'(emptyN), 1);
      repeat (2) @(negedge ldClk);
      flagCheck(63 - i, 3, 5);
    end

    unEn = 1'b1;                     // unload while empty
    repeat (2) @(negedge ldClk);
    unEn = 1'b0;
    chk("R3 empty stays", int'(emptyN), 0);
    loadOne(18'h2AAAA, 1'b1);
    repeat (2) @(negedge ldClk);
    chk("R3 no underflow emptyN", int'(emptyN), 1);
    chk("R3 no underflow head", int'(dataOut), 18'h2AAAA);

    // ---------- Test B: defaults (progEnN high on first strobe) ----------
    doReset();
    fillSweep(5000, 8, 8);
    repeat (2) @(negedge ldClk);
    chk("R9 default first word stored", int'(dataOut), 5000);

    // ---------- Test C: X=5, Y copied from X ----------
    doReset();
    loadOne(18'd5, 1'b0);
    fillSweep(7000, 5, 5);
    repeat (2) @(negedge ldClk);
    chk("R9 copy word stored", int'(dataOut), 7000);

    // ---------- Test D: unrelated clocks, scoreboard ----------
    asyncMode = 1'b1;
    doReset();
    prodDone = 1'b0;
    fork
      begin : producer
        logic [17:0] seq = 18'd20000;
        for (int i = 0; i < 400; i++) begin
          ldEn = 1'b0;
          if (i % 4 != 3) begin
            ldEn = 1'b1;
            dataIn = seq;
            if (fullN) q.push_back(seq);
            seq = seq + 18'd1;
          end
          @(negedge ldClk);
        end
        ldEn = 1'b0;
        prodDone = 1'b1;
      end
      begin : consumer
        repeat (150) @(negedge unClk);
        for (int k = 0; k < 2000; k++) begin
          if (prodDone && q.size() == 0) break;
          if (emptyN) begin
            if (q.size() == 0) begin
              chk("R2 unexpected word", int'(dataOut), -1);
              unEn = 1'b0;
            end else begin
              chk("R2 async order", int'(dataOut), int'(q[0]));
              void'(q.pop_front());
              unEn = 1'b1;
            end
          end else begin
            unEn = 1'b0;
          end
          @(negedge unClk);
        end
        unEn = 1'b0;
      end
    join
    repeat (4) @(negedge unClk);
    chk("R2 async all drained", q.size(), 0);
    chk("R5 async empty at end", int'(emptyN), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule